// File: doc/BRIEF.md
# Branch-Lookahead Instruction Prefetch Queue

This block sits between an instruction-fetch port and a decode stage. It holds a short FIFO of 32-bit instruction words and keeps it topped up with sequential fetch requests. Each returning word is inspected for a branch before it enters the FIFO. For a branch, a private adder forms the target, and a static rule or an already-known outcome gives the direction. A taken branch retargets the very next fetch, so the target words land in the FIFO directly behind the branch.

Two kinds of branch are folded: they are consumed without ever being presented to decode. These are unconditional branches and conditional branches whose outcome is already encoded as resolved. Any other branch is queued and issued in a single issue slot, together with its predicted direction. When execute finds a wrong prediction, it drives a redirect with the corrected PC. The redirect empties the FIFO, drops any outstanding fetch and restarts fetching at that PC. Responses to fetches issued before the redirect are recognised by a tag and thrown away.

The fetch port allows one request in flight and expects responses in request order, with a latency of one cycle or more.

Top module: `lookahead_fetch_queue`

## Requirements
- R1: The FIFO never holds more than DEPTH (default 6) words. A fetch request is offered only when no fetch is outstanding, the FIFO holds fewer than DEPTH words and no redirect is present. After an accepted request, no new request is offered until a matching response or a redirect arrives.
- R2: Unless a taken branch or a redirect intervenes, each accepted request at address A is followed by a request at A+4.
- R3: A word is a branch when bits [31:27] equal 5'b10010. In a branch, bit 26 set means conditional, bit 25 set means resolved, bit 24 is the resolved outcome (1 = taken) and bits [23:0] are a signed word displacement. The target is the branch's own address plus the sign-extended displacement times 4.
- R4: An unresolved conditional branch is predicted taken when its displacement is negative and not taken otherwise. Unconditional branches are always taken. Resolved conditionals follow bit 24.
- R5: When a taken branch arrives, the next fetch request is at its target. For an unresolved conditional branch predicted taken, the target words are the next FIFO entries after the branch.
- R6: Unconditional branches and resolved conditional branches never appear on the issue port. A taken folded branch retargets fetch. A not-taken folded branch lets fetch continue at its address plus 4.
- R7: Each non-folded word is presented exactly once, in one issue slot. iss_pred_taken is 1 only for a branch predicted taken, and iss_pc is the address the word was fetched from.
- R8: A redirect empties the FIFO by the next cycle and cancels the outstanding fetch. The next request goes to the corrected PC, and the fetch tag advances by one modulo 2^TAGW.
- R9: A response is ignored if its tag differs from the current tag, if no fetch is outstanding, or if it arrives in a redirect cycle.
- R10: Words issue in fetch order. While iss_valid is high and iss_ready is low, the presented word and PC stay unchanged.
- R11: After reset the FIFO is empty, no fetch is outstanding, the tag is 0 and the first request is at START_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Fetch request offered |
| req_ready | input | 1 | Fetch port accepts the request |
| req_addr | output | PCW | Fetch address |
| req_tag | output | TAGW | Epoch tag of the request |
| resp_valid | input | 1 | Fetch response present |
| resp_tag | input | TAGW | Tag echoed with the response |
| resp_data | input | 32 | Fetched instruction word |
| iss_valid | output | 1 | A word is presented to decode |
| iss_ready | input | 1 | Decode takes the word |
| iss_instr | output | 32 | Presented instruction word |
| iss_pc | output | PCW | Address of the presented word |
| iss_pred_taken | output | 1 | Presented word is a branch predicted taken |
| redir_valid | input | 1 | Execute-stage redirect |
| redir_pc | input | PCW | Corrected fetch address |

## Verification
The bench builds the block with DEPTH=6, PCW=32, TAGW=2 and START_PC=0x100. The narrow 2-bit tag wraps after four redirects. Stale responses can therefore carry a tag that later becomes current again, which exercises the rule that a response needs a fetch in flight. An address-hashed program image places every branch variant densely enough that long backward loops, back-to-back retargets and folded chains all occur. Decode backpressure alternates between light and heavy phases, so the full-queue request stall and the hold-while-stalled behaviour are both reached.

// File: rtl/lookahead_fetch_queue.sv
module lookahead_fetch_queue #(
  parameter int DEPTH = 6,
  parameter int PCW = 32,
  parameter int TAGW = 2,
  parameter logic [PCW-1:0] START_PC = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [PCW-1:0]  req_addr,
  output logic [TAGW-1:0] req_tag,
  input  logic            resp_valid,
  input  logic [TAGW-1:0] resp_tag,
  input  logic [31:0]     resp_data,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [31:0]     iss_instr,
  output logic [PCW-1:0]  iss_pc,
  output logic            iss_pred_taken,
  input  logic            redir_valid,
  input  logic [PCW-1:0]  redir_pc
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [4:0] BR_OP = 5'b10010;

  logic [31:0]     q_instr [DEPTH];
  logic [PCW-1:0]  q_pc    [DEPTH];
  logic            q_pred  [DEPTH];
  logic [PTRW-1:0] rd, wr;
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic [PCW-1:0]  fpc, rpc;
  logic [TAGW-1:0] tag;

  function automatic logic [PTRW-1:0] step(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire        resp_hit = resp_valid && busy && (resp_tag == tag) && !redir_valid;
  wire        is_br    = resp_data[31:27] == BR_OP;
  wire        is_cond  = resp_data[26];
  wire        is_res   = resp_data[25];
  wire        outcome  = resp_data[24];
  wire [23:0] disp     = resp_data[23:0];
  wire        fold     = is_br && (!is_cond || is_res);
  wire        take     = is_br && (!is_cond || (is_res ? outcome : disp[23]));
  wire [PCW-1:0] target = rpc + {{(PCW-26){disp[23]}}, disp, 2'b00};
  wire        push     = resp_hit && !fold;
  wire        pop      = iss_valid && iss_ready;
  wire        req_fire = req_valid && req_ready;

  assign req_valid      = !busy && (cnt < CNTW'(DEPTH)) && !redir_valid;
  assign req_addr       = fpc;
  assign req_tag        = tag;
  assign iss_valid      = cnt != '0;
  assign iss_instr      = q_instr[rd];
  assign iss_pc         = q_pc[rd];
  assign iss_pred_taken = q_pred[rd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd <= '0; wr <= '0; cnt <= '0; busy <= 1'b0;
      fpc <= START_PC; rpc <= START_PC; tag <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_instr[i] <= '0; q_pc[i] <= '0; q_pred[i] <= 1'b0;
      end
    end else if (redir_valid) begin
      rd <= '0; wr <= '0; cnt <= '0; busy <= 1'b0;
      fpc <= redir_pc;
      tag <= tag + 1'b1;
    end else begin
      if (push) begin
        q_instr[wr] <= resp_data;
        q_pc[wr]    <= rpc;
        q_pred[wr]  <= take;
        wr          <= step(wr);
      end
      if (pop) rd <= step(rd);
      cnt <= cnt + CNTW'(push) - CNTW'(pop);
      if (req_fire) begin
        busy <= 1'b1;
        rpc  <= fpc;
        fpc  <= fpc + PCW'(4);
      end
      if (resp_hit) begin
        busy <= 1'b0;
        if (take) fpc <= target;
      end
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));
  assert_single_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !iss_valid);
  assert_restart_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> req_addr == $past(redir_pc));
  assert_tag_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> req_tag == TAGW'($past(req_tag) + 1'b1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !redir_valid) |=> iss_valid && $stable(iss_pc) && $stable(iss_instr));
  assert_no_folded_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !(iss_instr[31:27] == BR_OP && (!iss_instr[26] || iss_instr[25])));
endmodule

// File: tb/lookahead_fetch_queue_test.sv
module lookahead_fetch_queue_test;
  localparam int DEPTH = 6;
  localparam logic [31:0] START = 32'h100;
  localparam int NCYC = 12000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, resp_valid, iss_valid, iss_ready, iss_pred_taken, redir_valid;
  logic [31:0] req_addr, resp_data, iss_instr, iss_pc, redir_pc;
  logic [1:0] req_tag, resp_tag;

  lookahead_fetch_queue #(.DEPTH(DEPTH), .PCW(32), .TAGW(2), .START_PC(START)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_tag(req_tag), .resp_valid(resp_valid), .resp_tag(resp_tag),
    .resp_data(resp_data), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_instr(iss_instr),
    .iss_pc(iss_pc), .iss_pred_taken(iss_pred_taken), .redir_valid(redir_valid), .redir_pc(redir_pc));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [31:0] i; logic [31:0] p; logic t; } ent_t;
  ent_t mq[$];
  bit m_busy;
  logic [31:0] m_fpc, m_rpc;
  logic [1:0] m_tag;

  typedef struct { logic [31:0] a; logic [1:0] tg; int due; } rsp_t;
  rsp_t rq[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", r, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mem(logic [31:0] a);
    int s = (int'(a[9:2]) * 5 + int'(a[13:10])) % 13;
    case (s)
      0: return {5'b10010, 3'b000, 24'd5};
      1: return {5'b10010, 3'b000, 24'hFFFFF7};
      2: return {5'b10010, 3'b100, 24'd3};
      3: return {5'b10010, 3'b100, 24'hFFFFFA};
      4: return {5'b10010, 3'b111, 24'd7};
      5: return {5'b10010, 3'b110, 24'd2};
      default: return {5'b00000, a[28:2] ^ 27'h0155AA};
    endcase
  endfunction

  function automatic logic [31:0] tgt(logic [31:0] pc, logic [23:0] d);
    int off = int'(signed'({{8{d[23]}}, d})) * 4;
    return pc + off;
  endfunction

  task automatic model_step(bit rv, logic [31:0] rp, bit pv, logic [1:0] pt, logic [31:0] pd,
                            bit ir, bit qr);
    bit rqv;
    rqv = !m_busy && mq.size() < DEPTH && !rv;
    if (rv) begin
      mq.delete(); m_busy = 0; m_fpc = rp; m_tag = m_tag + 2'd1;
      return;
    end
    if (mq.size() > 0 && ir) void'(mq.pop_front());
    if (rqv && qr) begin m_busy = 1; m_rpc = m_fpc; m_fpc = m_fpc + 4; end
    else if (pv && m_busy && pt == m_tag) begin
      bit br, cnd, res, tk;
      br = pd[31:27] == 5'b10010; cnd = pd[26]; res = pd[25];
      tk = br && (!cnd || (res ? pd[24] : pd[23]));
      m_busy = 0;
      if (!(br && (!cnd || res))) mq.push_back('{i: pd, p: m_rpc, t: tk});
      if (tk) m_fpc = tgt(m_rpc, pd[23:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit e_rv, fire;
    logic [31:0] fa;
    logic [1:0] ft;
    rst_n = 0; req_ready = 0; resp_valid = 0; resp_tag = 0; resp_data = 0;
    iss_ready = 0; redir_valid = 0; redir_pc = 0;
    mq.delete(); m_busy = 0; m_fpc = START; m_rpc = START; m_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R11 iss_valid after reset", iss_valid, 0);
    chk("R11 req_valid after reset", req_valid, 1);
    chk("R11 req_addr after reset", req_addr, START);
    chk("R11 req_tag after reset", req_tag, 0);
    for (int c = 0; c < NCYC; c++) begin
      int rdy_mod = (c < 4000) ? 2 : (c < 7000) ? 8 : 1;
      iss_ready = (rdy_mod == 1) ? ($urandom % 8 != 0) : (rdy_mod == 2) ? ($urandom % 2 == 0) : ($urandom % 8 == 0);
      req_ready = ($urandom % 4 != 0);
      e_rv = ($urandom % 45 == 0);
      redir_valid = e_rv;
      redir_pc = e_rv ? {18'd0, 4'($urandom), 8'($urandom), 2'b00} : 32'h0;
      if (rq.size() > 0 && cyc >= rq[0].due) begin
        resp_valid = 1; resp_tag = rq[0].tg; resp_data = mem(rq[0].a);
      end else begin
        resp_valid = 0; resp_tag = 0; resp_data = 0;
      end
      #1;
      chk("R1 req_valid", req_valid, (!m_busy && mq.size() < DEPTH && !e_rv));
      if (req_valid) begin
        chk("R2/R3/R5/R6/R8 req_addr", req_addr, m_fpc);
        chk("R8/R9 req_tag", req_tag, m_tag);
      end
      chk("R7/R8 iss_valid", iss_valid, mq.size() > 0);
      if (mq.size() > 0) begin
        chk("R7/R10 iss_instr", iss_instr, mq[0].i);
        chk("R7/R10 iss_pc", iss_pc, mq[0].p);
        chk("R4/R5/R7 iss_pred_taken", iss_pred_taken, mq[0].t);
      end
      fire = req_valid && req_ready; fa = req_addr; ft = req_tag;
      @(posedge clk);
      cyc++;
      model_step(e_rv, redir_pc, resp_valid, resp_tag, resp_data, iss_ready, req_ready);
      if (resp_valid) void'(rq.pop_front());
      if (fire) rq.push_back('{a: fa, tg: ft, due: cyc + 1 + int'($urandom % 3)});
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule